// File: doc/BRIEF.md
# Indirect Register Access Mailbox

This block lets a host reach an internal byte-wide register file without mapping every register into its address space. The host sees only three byte locations: a data port, a shared location that reads as status and accepts command bytes when written, and a plain interrupt-control holding byte. A register access is carried out as a short byte stream. The host sends a command code, then a register index, then, for a write, the value. A status flag reports whether the mailbox still holds an unconsumed host byte, and another reports whether a result byte is waiting to be read.

Inside the block, a small sequencer takes each host byte one clock after it arrives. It tracks where the current access has reached and, once the stream is complete, issues a single request on an internal register bus. The request uses a request/acknowledge handshake and holds its index, direction and write data steady until the acknowledge arrives. Read data returned with the acknowledge is placed in the output buffer for the host to collect.

Top module: `ind_reg_mailbox`

## Requirements
- R1: After reset, the status byte reads 0x00, the interrupt-control byte reads 0x00 and no register-bus request is active.
- R2: A host write to offset 0x00 or 0x04 sets the input-full flag (status bit 1) at that clock edge and latches the byte. The sequencer takes the byte one clock later, which clears the flag. While a register-bus operation is in flight, the byte waits and the flag stays set. A host write to either of these offsets while the flag is set is dropped.
- R3: Reading offset 0x04 returns the status byte: bit 0 output-full, bit 1 input-full, bit 3 last-byte-was-command, all other bits zero. Reading offset 0x00 returns the output buffer. Reading any offset other than 0x00, 0x04 and 0x08 returns 0x00.
- R4: A read access is command 0x80 at offset 0x04 followed by the index at offset 0x00. It raises a request with write-enable low and that index. The byte returned with the acknowledge is loaded into the output buffer, and output-full (bit 0) sets at that same edge.
- R5: A write access is command 0x81, then the index, then the value, the last two at offset 0x00. It raises a request with write-enable high, that index and that value.
- R6: A host read strobe on offset 0x00 clears output-full at the next clock edge.
- R7: Taking any command byte clears output-full and restarts the sequence, abandoning any partly received access.
- R8: A data-port byte that arrives with no valid command pending is discarded without any bus request. A data-port write clears the command flag and a command-port write sets it.
- R9: A command byte other than 0x80 or 0x81 leaves the sequencer idle, so the data-port bytes that follow it start no bus request.
- R10: Offset 0x08 is a read/write holding byte that has no effect on the flags or the sequencer.
- R11: Once raised, the bus request stays high with index, direction and write data unchanged until the cycle that carries the acknowledge, and it drops after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | ADDR_W | Host byte offset (0x00 data, 0x04 status/command, 0x08 interrupt control) |
| host_wr | input | 1 | Host write strobe, one per clock |
| host_rd | input | 1 | Host read strobe (side effect only on offset 0x00) |
| host_wdata | input | DATA_W | Host write byte |
| host_rdata | output | DATA_W | Read-back byte for the current host_addr |
| reg_req | output | 1 | Register-bus request, held until acknowledged |
| reg_we | output | 1 | Register-bus direction, 1 for write |
| reg_idx | output | IDX_W | Register index |
| reg_wdata | output | DATA_W | Register write value |
| reg_rdata | input | DATA_W | Register read value, valid with reg_ack |
| reg_ack | input | 1 | Register-bus acknowledge |

## Verification
The bench builds the block with DATA_W=8, IDX_W=8, ADDR_W=4 and the default codes 0x80 and 0x81. Its register-file model answers each request only after three waiting cycles. That window is long enough to land host writes while a bus operation is open, which brings within reach the held input-full flag, a dropped second write and a command waiting behind a read. The byte-wide index covers the whole 256-entry register space, so the bench can check arbitrary index values and that each write lands at its own index.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Sequencer phases: waiting for a byte, or driving the register bus.
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_RD_IDX = 3'd1,
    PH_WR_IDX = 3'd2,
    PH_WR_VAL = 3'd3,
    PH_BUS_RD = 3'd4,
    PH_BUS_WR = 3'd5
  } phase_t;

  // Host byte offsets.
  localparam int unsigned OFS_DATA = 'h0;
  localparam int unsigned OFS_CTRL = 'h4;
  localparam int unsigned OFS_ICTL = 'h8;

  // Low nibble of the status byte: {last_cmd, 0, in_full, out_full}.
  function automatic logic [3:0] pack_status(input logic out_full,
                                             input logic in_full,
                                             input logic last_cmd);
    return {last_cmd, 1'b0, in_full, out_full};
  endfunction

  function automatic phase_t decode_cmd(input logic is_rd, input logic is_wr);
    if (is_rd) return PH_RD_IDX;
    if (is_wr) return PH_WR_IDX;
    return PH_IDLE;
  endfunction

  function automatic phase_t phase_after_data(input phase_t p);
    case (p)
      PH_RD_IDX: return PH_BUS_RD;
      PH_WR_IDX: return PH_WR_VAL;
      PH_WR_VAL: return PH_BUS_WR;
      default:   return PH_IDLE;
    endcase
  endfunction

  function automatic logic phase_takes_byte(input phase_t p);
    return (p == PH_IDLE) || (p == PH_RD_IDX) || (p == PH_WR_IDX) || (p == PH_WR_VAL);
  endfunction

  function automatic logic phase_on_bus(input phase_t p);
    return (p == PH_BUS_RD) || (p == PH_BUS_WR);
  endfunction

endpackage

// File: rtl/mbx_host_port.sv
module mbx_host_port
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              take,
  input  logic              out_full,
  input  logic [DATA_W-1:0] out_byte,
  output logic              in_full,
  output logic [DATA_W-1:0] in_byte,
  output logic              in_is_cmd,
  output logic              data_pop
);

  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_ICTL = ADDR_W'(OFS_ICTL);
  localparam int unsigned PAD_W = DATA_W - 4;

  logic sel_data, sel_ctrl, sel_ictl;
  logic wr_accept;
  logic last_cmd_q;
  logic [DATA_W-1:0] ictl_q;

  assign sel_data  = (host_addr == A_DATA);
  assign sel_ctrl  = (host_addr == A_CTRL);
  assign sel_ictl  = (host_addr == A_ICTL);
  assign wr_accept = host_wr && (sel_data || sel_ctrl) && !in_full;
  assign data_pop  = host_rd && sel_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_full    <= 1'b0;
      in_byte    <= '0;
      in_is_cmd  <= 1'b0;
      last_cmd_q <= 1'b0;
    end else if (wr_accept) begin
      in_full    <= 1'b1;
      in_byte    <= host_wdata;
      in_is_cmd  <= sel_ctrl;
      last_cmd_q <= sel_ctrl;
    end else if (take) begin
      in_full    <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ictl_q <= '0;
    else if (host_wr && sel_ictl) ictl_q <= host_wdata;
  end

  always_comb begin
    host_rdata = '0;
    if (sel_data)      host_rdata = out_byte;
    else if (sel_ctrl) host_rdata = {{PAD_W{1'b0}}, pack_status(out_full, in_full, last_cmd_q)};
    else if (sel_ictl) host_rdata = ictl_q;
  end

  // R2
  take_has_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> in_full);

  // R2
  byte_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_full && !take) |=> (in_full && $stable(in_byte) && $stable(in_is_cmd)));

endmodule

// File: rtl/mbx_outbuf.sv
module mbx_outbuf #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              flush,
  input  logic              pop,
  output logic              out_full,
  output logic [DATA_W-1:0] out_byte
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_full <= 1'b0;
      out_byte <= '0;
    end else if (load) begin
      out_full <= 1'b1;
      out_byte <= load_data;
    end else if (flush || pop) begin
      out_full <= 1'b0;
    end
  end

  // R6
  pop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !load) |=> !out_full);

endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned CMD_RD = 'h80,
  parameter int unsigned CMD_WR = 'h81
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_full,
  input  logic [DATA_W-1:0] in_byte,
  input  logic              in_is_cmd,
  output logic              take,
  output logic              flush,
  output logic              reg_req,
  output logic              reg_we,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic              reg_ack,
  output logic              load,
  output logic [DATA_W-1:0] load_data
);

  localparam logic [DATA_W-1:0] RD_CODE = DATA_W'(CMD_RD);
  localparam logic [DATA_W-1:0] WR_CODE = DATA_W'(CMD_WR);

  phase_t phase_q, phase_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] val_q, val_d;
  logic is_rd, is_wr, bad_cmd, bus_done, take_data;

  assign take      = in_full && phase_takes_byte(phase_q);
  assign flush     = take && in_is_cmd;
  assign take_data = take && !in_is_cmd;
  assign is_rd     = (in_byte == RD_CODE);
  assign is_wr     = (in_byte == WR_CODE);
  assign bad_cmd   = flush && !is_rd && !is_wr;
  assign bus_done  = reg_ack && phase_on_bus(phase_q);

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    val_d   = val_q;
    if (flush) begin
      phase_d = decode_cmd(is_rd, is_wr);
    end else if (take_data) begin
      phase_d = phase_after_data(phase_q);
      if (phase_q == PH_RD_IDX || phase_q == PH_WR_IDX) idx_d = in_byte[IDX_W-1:0];
      if (phase_q == PH_WR_VAL) val_d = in_byte;
    end else if (bus_done) begin
      phase_d = PH_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      val_q   <= '0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      val_q   <= val_d;
    end
  end

  assign reg_req   = phase_on_bus(phase_q);
  assign reg_we    = (phase_q == PH_BUS_WR);
  assign reg_idx   = idx_q;
  assign reg_wdata = val_q;
  assign load      = bus_done && (phase_q == PH_BUS_RD);
  assign load_data = reg_rdata;

  // R11
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_ack) |=> (reg_req && $stable(reg_idx) && $stable(reg_we) && $stable(reg_wdata)));

  // R11
  bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_ack) |=> !reg_req);

  // R9
  bad_cmd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cmd |=> (phase_q == PH_IDLE));

  // R8
  stray_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_data && phase_q == PH_IDLE) |=> !reg_req);

endmodule

// File: rtl/ind_reg_mailbox.sv
module ind_reg_mailbox #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned CMD_RD = 'h80,
  parameter int unsigned CMD_WR = 'h81
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              reg_req,
  output logic              reg_we,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic              reg_ack
);

  logic              in_full, in_is_cmd, take, flush, data_pop;
  logic [DATA_W-1:0] in_byte;
  logic              out_full, load;
  logic [DATA_W-1:0] out_byte, load_data;

  mbx_host_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst_n(rst_n),
    .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .take(take), .out_full(out_full), .out_byte(out_byte),
    .in_full(in_full), .in_byte(in_byte), .in_is_cmd(in_is_cmd),
    .data_pop(data_pop)
  );

  mbx_seq #(.DATA_W(DATA_W), .IDX_W(IDX_W), .CMD_RD(CMD_RD), .CMD_WR(CMD_WR)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .in_full(in_full), .in_byte(in_byte), .in_is_cmd(in_is_cmd),
    .take(take), .flush(flush),
    .reg_req(reg_req), .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_ack(reg_ack),
    .load(load), .load_data(load_data)
  );

  mbx_outbuf #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .load(load), .load_data(load_data),
    .flush(flush), .pop(data_pop),
    .out_full(out_full), .out_byte(out_byte)
  );

  // R7
  no_stale_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |-> !out_full);

  // R4
  out_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_full) |-> ($past(reg_ack) && !$past(reg_we) && $past(reg_req)));

  // R7
  cmd_flushes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_full);

endmodule

// File: tb/ind_reg_mailbox_bench.sv
module ind_reg_mailbox_bench;
  localparam int ACK_LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [3:0] host_addr = 4'h0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       reg_req, reg_we;
  logic [7:0] reg_idx, reg_wdata;
  logic [7:0] reg_rdata = 8'h00;
  logic       reg_ack = 1'b0;

  int checks = 0, fails = 0;
  bit done_flag = 0;

  ind_reg_mailbox u_ind_reg_mailbox (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .reg_req(reg_req), .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_ack(reg_ack)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Register file model with a fixed answer delay.
  logic [7:0] mem [256];
  int lat_cnt = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      reg_ack = 1'b0; lat_cnt = 0;
    end else if (reg_ack) begin
      reg_ack = 1'b0; lat_cnt = 0;
    end else if (reg_req) begin
      if (lat_cnt >= ACK_LAT) begin
        reg_ack = 1'b1;
        reg_rdata = mem[reg_idx];
        if (reg_we) mem[reg_idx] = reg_wdata;
      end else begin
        lat_cnt++;
      end
    end
  end

  // Behavioural reference: phase 0 idle, 1 want read index, 2 want write index,
  // 3 want value, 4 reading on bus, 5 writing on bus.
  int m_phase = 0;
  bit m_ibf = 0, m_iscmd = 0, m_cmd = 0, m_obf = 0;
  logic [7:0] m_byte = 0, m_out = 0, m_ictl = 0, m_idx = 0, m_val = 0;
  bit m_consume, m_accept, m_done;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_ibf = 0; m_iscmd = 0; m_cmd = 0; m_obf = 0;
      m_byte = 0; m_out = 0; m_ictl = 0; m_idx = 0; m_val = 0;
    end else begin
      m_consume = m_ibf && (m_phase < 4);
      m_accept  = host_wr && !m_ibf && (host_addr == 4'h0 || host_addr == 4'h4);
      m_done    = reg_ack && (m_phase >= 4);
      if (host_rd && host_addr == 4'h0) m_obf = 0;
      if (m_consume) begin
        m_ibf = 0;
        if (m_iscmd) begin
          m_obf = 0;
          m_phase = (m_byte == 8'h80) ? 1 : (m_byte == 8'h81) ? 2 : 0;
        end else if (m_phase == 1) begin
          m_idx = m_byte; m_phase = 4;
        end else if (m_phase == 2) begin
          m_idx = m_byte; m_phase = 3;
        end else if (m_phase == 3) begin
          m_val = m_byte; m_phase = 5;
        end
      end
      if (m_done) begin
        if (m_phase == 4) begin m_obf = 1; m_out = reg_rdata; end
        m_phase = 0;
      end
      if (m_accept) begin
        m_ibf = 1; m_byte = host_wdata;
        m_iscmd = (host_addr == 4'h4); m_cmd = (host_addr == 4'h4);
      end
      if (host_wr && host_addr == 4'h8) m_ictl = host_wdata;
    end
  end

  logic [7:0] exp_rd;
  always @(posedge clk) begin
    #1;
    if (rst_n && !done_flag) begin
      case (host_addr)
        4'h0: exp_rd = m_out;
        4'h4: exp_rd = {4'b0, m_cmd, 1'b0, m_ibf, m_obf};
        4'h8: exp_rd = m_ictl;
        default: exp_rd = 8'h00;
      endcase
      chk(host_rdata == exp_rd, "R3 per-cycle readback", host_rdata, exp_rd);
      chk(reg_req == (m_phase >= 4), "R11 per-cycle request", reg_req, (m_phase >= 4));
      if (m_phase >= 4) begin
        chk(reg_we == (m_phase == 5), "R5 per-cycle direction", reg_we, (m_phase == 5));
        chk(reg_idx == m_idx, "R11 per-cycle index", reg_idx, m_idx);
        if (m_phase == 5) chk(reg_wdata == m_val, "R5 per-cycle value", reg_wdata, m_val);
      end
    end
  end

  // Host helpers.
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wr = 1'b1; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic peek_now(input logic [3:0] a, output logic [7:0] v);
    host_addr = a;
    #2;
    v = host_rdata;
  endtask

  task automatic rd_data(output logic [7:0] v);
    @(negedge clk);
    host_addr = 4'h0; host_rd = 1'b1;
    #2;
    v = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic wait_ibf_clear();
    logic [7:0] v;
    for (int i = 0; i < 50; i++) begin
      peek_now(4'h4, v);
      if (!v[1]) break;
      @(negedge clk);
    end
  endtask

  task automatic wait_obf();
    logic [7:0] v;
    for (int i = 0; i < 50; i++) begin
      peek_now(4'h4, v);
      if (v[0]) break;
      @(negedge clk);
    end
  endtask

  task automatic wait_bus_idle();
    for (int i = 0; i < 50; i++) begin
      #2;
      if (!reg_req) break;
      @(negedge clk);
    end
  endtask

  task automatic do_write(input logic [7:0] idx, input logic [7:0] val);
    wr(4'h4, 8'h81); wait_ibf_clear();
    wr(4'h0, idx);   wait_ibf_clear();
    wr(4'h0, val);   wait_ibf_clear();
    @(negedge clk);
    wait_bus_idle();
  endtask

  task automatic start_read(input logic [7:0] idx);
    wr(4'h4, 8'h80); wait_ibf_clear();
    wr(4'h0, idx);   wait_ibf_clear();
    wait_obf();
  endtask

  task automatic no_req_for(input int n, input string tag);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (reg_req) seen = 1;
    end
    chk(!seen, tag, seen, 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++; fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1
    peek_now(4'h4, v); chk(v == 8'h00, "R1 status after reset", v, 8'h00);
    peek_now(4'h8, v); chk(v == 8'h00, "R1 ictl after reset", v, 8'h00);
    chk(reg_req == 1'b0, "R1 no request after reset", reg_req, 0);

    // R2 / R3 / R4 / R6: read of index 0x12
    wr(4'h4, 8'h80);
    peek_now(4'h4, v); chk(v == 8'h0A, "R2 ibf and cmd flag after command", v, 8'h0A);
    @(negedge clk);
    peek_now(4'h4, v); chk(v == 8'h08, "R2 ibf clears one clock later", v, 8'h08);
    wr(4'h0, 8'h12);
    peek_now(4'h4, v); chk(v == 8'h02, "R8 data write clears cmd flag", v, 8'h02);
    wait_ibf_clear();
    wait_obf();
    peek_now(4'h4, v); chk(v == 8'h01, "R4 obf set after read", v, 8'h01);
    rd_data(v); chk(v == mem[8'h12], "R4 read data", v, mem[8'h12]);
    peek_now(4'h4, v); chk(v == 8'h00, "R6 obf cleared by data read", v, 8'h00);

    // R5: write then read back
    do_write(8'h33, 8'hC3);
    chk(mem[8'h33] == 8'hC3, "R5 register written", mem[8'h33], 8'hC3);
    start_read(8'h33);
    rd_data(v); chk(v == 8'hC3, "R5 readback of written value", v, 8'hC3);

    // R8: stray data byte in idle
    wr(4'h0, 8'h44);
    no_req_for(8, "R8 stray data byte starts no request");
    peek_now(4'h4, v); chk(v == 8'h00, "R8 cmd flag clear after stray byte", v, 8'h00);

    // R9: unknown command
    wr(4'h4, 8'h7F); wait_ibf_clear();
    wr(4'h0, 8'h21); wait_ibf_clear();
    no_req_for(8, "R9 unknown command starts no request");

    // R7: stale obf cleared by a new command, and restart mid-sequence
    start_read(8'h05);
    wr(4'h4, 8'h81); wait_ibf_clear();
    peek_now(4'h4, v); chk(v[0] == 1'b0, "R7 new command clears obf", v[0], 0);
    wr(4'h0, 8'h40); wait_ibf_clear();
    wr(4'h4, 8'h80); wait_ibf_clear();
    wr(4'h0, 8'h06); wait_ibf_clear();
    wait_obf();
    rd_data(v); chk(v == mem[8'h06], "R7 restarted access reads new index", v, mem[8'h06]);
    chk(mem[8'h40] == 8'(8'h40 * 7 + 3), "R7 abandoned write left register", mem[8'h40], 8'(8'h40 * 7 + 3));

    // R2: byte held while bus busy; write while full is dropped
    wr(4'h4, 8'h80); wait_ibf_clear();
    wr(4'h0, 8'h07);
    @(negedge clk);
    wr(4'h4, 8'h81);
    wr(4'h0, 8'h99);
    begin
      bit held = 1;
      for (int i = 0; i < 20; i++) begin
        #2;
        if (!reg_req) break;
        if (!host_rdata[1] && host_addr == 4'h0) held = held;
        peek_now(4'h4, v);
        if (!v[1]) held = 0;
        @(negedge clk);
      end
      chk(held, "R2 ibf held during bus operation", held, 1);
    end
    wait_ibf_clear();
    wr(4'h0, 8'h50); wait_ibf_clear();
    wr(4'h0, 8'h77); wait_ibf_clear();
    @(negedge clk);
    wait_bus_idle();
    chk(mem[8'h50] == 8'h77, "R2 write while full dropped", mem[8'h50], 8'h77);
    chk(mem[8'h99] == 8'(8'h99 * 7 + 3), "R2 dropped byte not used", mem[8'h99], 8'(8'h99 * 7 + 3));

    // R10: interrupt-control holding byte
    wr(4'h8, 8'hA5);
    peek_now(4'h8, v); chk(v == 8'hA5, "R10 ictl readback", v, 8'hA5);
    peek_now(4'h4, v); chk(v == 8'h00, "R10 ictl write leaves status", v, 8'h00);
    no_req_for(4, "R10 ictl write starts no request");
    peek_now(4'hC, v); chk(v == 8'h00, "R3 unused offset reads zero", v, 8'h00);

    repeat (4) @(negedge clk);
    done_flag = 1;
    summary();
    $finish;
  end

endmodule